// File: doc/BRIEF.md
# Six-Strobe Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit. It takes two operands and a six-bit control code, and it returns a result word with two status flags. The unit has no opcode table. Every function comes from the same fixed chain of steps. First, each operand may be cleared and may then be complemented. Next, the two conditioned operands are either summed or ANDed bit by bit. Last, that value may be complemented. Each step answers to exactly one bit of the control code.

A caller picks a function by choosing the pattern of the six bits. For example, a code can clear both operands and complement one of them to produce constants, or it can pass an operand through, negate it, or add or subtract the operands. The zero and negative flags settle in the same cycle as the result, so a surrounding sequencer can base a branch decision on them without waiting for a register stage. The operand width is a parameter with a default of 16.

Top module: `alu6_core`

## Requirements
- R1: Control bit 5 (clear-A) set makes the A operand behave as all zeros before any later step.
- R2: Control bit 4 (flip-A) complements the A operand after the clear step. With bits 5 and 4 both set, A behaves as all ones.
- R3: Control bit 3 (clear-B) set makes the B operand behave as all zeros before any later step.
- R4: Control bit 2 (flip-B) complements the B operand after the clear step. With bits 3 and 2 both set, B behaves as all ones.
- R5: Control bit 1 selects the combine step. A value of 1 sums the conditioned operands, and a value of 0 ANDs them bit by bit.
- R6: Control bit 0 (flip-out) set complements the combined value to form the result.
- R7: `isZero` is 1 exactly when every bit of `result` is 0.
- R8: `isNeg` always equals the most significant bit of `result`.
- R9: The sum wraps modulo 2^W, and the carry out of the top bit does not appear in any output.
- R10: The outputs follow an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | W | First operand |
| opB | input | W | Second operand |
| ctrl | input | 6 | Control code: bit 5 clear-A, bit 4 flip-A, bit 3 clear-B, bit 2 flip-B, bit 1 add/AND select, bit 0 flip-out |
| result | output | W | Final result word |
| isZero | output | 1 | High when result is all zeros |
| isNeg | output | 1 | Copy of result's top bit |

## Verification
The bench builds the unit at the default width of 16. At that width the wrap-around of the sum and the top-bit sign flag can be reached with a few chosen operands: 0xFFFF, 0x8000, 0x7FFF and 0. The bench pairs each of these operands with every other one under all 64 control codes, and it adds random operand pairs. This covers every clear/flip/combine ordering against a behavioural reference model. Directed cases then isolate each control bit, and one case changes the inputs between clock edges to show that the path has no register.

// File: rtl/alu6_pkg.sv
package alu6_pkg;
  localparam int CTRL_BITS = 6;

  // One strobe per pipeline step, in control-code order (MSB first).
  typedef struct packed {
    logic zeroX;
    logic negX;
    logic zeroY;
    logic negY;
    logic addSel;
    logic negOut;
  } aluStrobes_t;
endpackage

// File: rtl/alu6_operand_prep.sv
module alu6_operand_prep #(
  parameter int W = 16
) (
  input  logic [W-1:0] raw,
  input  logic         clear,
  input  logic         flip,
  output logic [W-1:0] shaped
);
  logic [W-1:0] cleared;

  // Clear happens first; the complement acts on the cleared value.
  assign cleared = clear ? '0 : raw;
  assign shaped  = flip ? ~cleared : cleared;
endmodule

// File: rtl/alu6_flags.sv
module alu6_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] value,
  output logic         isZero,
  output logic         isNeg
);
  assign isZero = ~|value;
  assign isNeg  = value[W-1];
endmodule

// File: rtl/alu6_ctrl.sv
module alu6_ctrl
  import alu6_pkg::*;
(
  input  logic [CTRL_BITS-1:0] code,
  output aluStrobes_t          strobes
);
  always_comb begin
    strobes.zeroX  = code[5];
    strobes.negX   = code[4];
    strobes.zeroY  = code[3];
    strobes.negY   = code[2];
    strobes.addSel = code[1];
    strobes.negOut = code[0];
  end
endmodule

// File: rtl/alu6_datapath.sv
module alu6_datapath
  import alu6_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluStrobes_t  strobes,
  output logic [W-1:0] result,
  output logic         isZero,
  output logic         isNeg
);
  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][W-1:0] rawOps;
  logic [NUM_OPS-1:0][W-1:0] shapedOps;
  logic [NUM_OPS-1:0]        clearOps;
  logic [NUM_OPS-1:0]        flipOps;
  logic [W-1:0]              sumVal;
  logic [W-1:0]              andVal;
  logic [W-1:0]              combined;

  assign rawOps[0]   = opA;
  assign rawOps[1]   = opB;
  assign clearOps[0] = strobes.zeroX;
  assign clearOps[1] = strobes.zeroY;
  assign flipOps[0]  = strobes.negX;
  assign flipOps[1]  = strobes.negY;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_prep
    alu6_operand_prep #(.W(W)) u_prep (
      .raw   (rawOps[i]),
      .clear (clearOps[i]),
      .flip  (flipOps[i]),
      .shaped(shapedOps[i])
    );
  end

  // The sum is kept at W bits, so the carry out of the top bit is dropped.
  assign sumVal   = shapedOps[0] + shapedOps[1];
  assign andVal   = shapedOps[0] & shapedOps[1];
  assign combined = strobes.addSel ? sumVal : andVal;
  assign result   = strobes.negOut ? ~combined : combined;

  alu6_flags #(.W(W)) u_flags (
    .value (result),
    .isZero(isZero),
    .isNeg (isNeg)
  );
endmodule

// File: rtl/alu6_core.sv
module alu6_core
  import alu6_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]         opA,
  input  logic [W-1:0]         opB,
  input  logic [CTRL_BITS-1:0] ctrl,
  output logic [W-1:0]         result,
  output logic                 isZero,
  output logic                 isNeg
);
  aluStrobes_t strobes;

  alu6_ctrl u_ctrl (
    .code   (ctrl),
    .strobes(strobes)
  );

  alu6_datapath #(.W(W)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .strobes(strobes),
    .result (result),
    .isZero (isZero),
    .isNeg  (isNeg)
  );
endmodule

// File: rtl/alu6_core_chk.sv
module alu6_core_chk
  import alu6_pkg::*;
#(
  parameter int W = 16
) (
  input logic [W-1:0]         opA,
  input logic [W-1:0]         opB,
  input logic [CTRL_BITS-1:0] ctrl,
  input logic [W-1:0]         result,
  input logic                 isZero,
  input logic                 isNeg
);
  always_comb begin
    // R7: the zero flag tracks an all-zero result
    assert_zero_flag_R7: assert (isZero == (result == '0))
      else $error("zero flag mismatch");
    // R8: the negative flag tracks the top result bit
    assert_neg_flag_R8: assert (isNeg == result[W-1])
      else $error("negative flag mismatch");
    // R9: a plain sum wraps modulo 2^W
    if (ctrl == 6'b000010) begin
      assert_wrap_sum_R9: assert (result == W'(opA + opB))
        else $error("sum mismatch");
    end
    // R5: function bit clear gives bitwise AND
    if (ctrl == 6'b000000) begin
      assert_and_select_R5: assert (result == (opA & opB))
        else $error("and mismatch");
    end
    // R1/R3: both operands cleared and summed gives zero
    if (ctrl == 6'b101010) begin
      assert_clear_both_R1: assert (result == '0)
        else $error("clear mismatch");
    end
    // R2: clear then flip on A gives all ones, ANDed with B passes B
    if (ctrl == 6'b110000) begin
      assert_ones_a_R2: assert (result == opB)
        else $error("ones-A mismatch");
    end
    // R4: clear then flip on B gives all ones, ANDed with A passes A
    if (ctrl == 6'b001100) begin
      assert_ones_b_R4: assert (result == opA)
        else $error("ones-B mismatch");
    end
  end
endmodule

bind alu6_core alu6_core_chk #(.W(W)) u_chk (
  .opA   (opA),
  .opB   (opB),
  .ctrl  (ctrl),
  .result(result),
  .isZero(isZero),
  .isNeg (isNeg)
);

// File: tb/alu6_core_tb.sv
`timescale 1ns/1ps
module alu6_core_tb;
  localparam int W = 16;
  localparam logic [W-1:0] ALL1 = '1;
  localparam logic [W-1:0] TOPB = ALL1 ^ (ALL1 >> 1);
  localparam logic [W-1:0] MAXP = ALL1 >> 1;

  logic         clk = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [5:0]   ctrl = '0;
  logic [W-1:0] result;
  logic         isZero;
  logic         isNeg;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu6_core #(.W(W)) u_dut (
    .opA(opA), .opB(opB), .ctrl(ctrl),
    .result(result), .isZero(isZero), .isNeg(isNeg)
  );

  // Behavioural reference: integers and masks, complement as mask minus value.
  function automatic logic [W-1:0] refModel(logic [W-1:0] a, logic [W-1:0] b, logic [5:0] c);
    longint mask = (longint'(1) << W) - 1;
    longint x = longint'(a);
    longint y = longint'(b);
    longint v;
    if (c[5]) x = 0;
    if (c[4]) x = mask - x;
    if (c[3]) y = 0;
    if (c[2]) y = mask - y;
    if (c[1]) v = (x + y) % (mask + 1);
    else      v = x & y;
    if (c[0]) v = mask - v;
    return W'(v);
  endfunction

  task automatic expectVal(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ctrl=%b a=%h b=%h actual=%h expected=%h", tag, ctrl, opA, opB, act, exp);
    end
  endtask

  // Drive after a rising edge, sample at the following falling edge.
  task automatic runCase(string tag, logic [W-1:0] a, logic [W-1:0] b, logic [5:0] c);
    logic [W-1:0] exp;
    @(posedge clk);
    opA = a; opB = b; ctrl = c;
    @(negedge clk);
    exp = refModel(a, b, c);
    expectVal(tag, result, exp);
    expectVal("R7", W'(isZero), W'(exp == '0));
    expectVal("R8", W'(isNeg), W'(exp[W-1]));
  endtask

  initial begin
    logic [W-1:0] edgeVals [4];
    edgeVals[0] = '0; edgeVals[1] = ALL1; edgeVals[2] = TOPB; edgeVals[3] = MAXP;

    // Quiet state: all inputs zero gives a zero result and raised zero flag.
    runCase("R5", '0, '0, 6'b000000);

    // Directed cases, one per control step.
    runCase("R1", 16'h1234, 16'h0001, 6'b100010);   // clear A: result = B
    runCase("R2", 16'h1234, 16'h5A5A, 6'b110000);   // A all ones: AND passes B
    runCase("R2", 16'h00F0, 16'hFFFF, 6'b010000);   // flip A only
    runCase("R3", 16'h4321, 16'hBEEF, 6'b001010);   // clear B: result = A
    runCase("R4", 16'hC3C3, 16'h7777, 6'b001100);   // B all ones: AND passes A
    runCase("R4", 16'hFFFF, 16'h0F0F, 6'b000100);   // flip B only
    runCase("R5", 16'hF0F0, 16'h3C3C, 6'b000000);   // AND
    runCase("R5", 16'h0F0F, 16'h1111, 6'b000010);   // add
    runCase("R6", 16'h0000, 16'h0000, 6'b000001);   // flipped AND of zeros = ones
    runCase("R6", 16'h0003, 16'h0005, 6'b000011);   // flipped sum
    runCase("R9", ALL1, 16'h0001, 6'b000010);       // carry dropped -> zero
    runCase("R9", TOPB, TOPB, 6'b000010);           // carry dropped -> zero
    runCase("R8", MAXP, 16'h0001, 6'b000010);       // crosses into sign bit
    runCase("R7", 16'h0001, ALL1, 6'b000010);       // zero flag from wrap

    // R10: change inputs mid-cycle, with no clock edge, and check after a short delay.
    @(posedge clk);
    opA = 16'h0002; opB = 16'h0003; ctrl = 6'b000010;
    #1;
    expectVal("R10", result, 16'h0005);
    opB = 16'h0010;
    #1;
    expectVal("R10", result, 16'h0012);

    // Sweep all 64 codes over edge pairs and random pairs.
    for (int c = 0; c < 64; c++) begin
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          runCase("R5", edgeVals[i], edgeVals[j], 6'(c));
      for (int k = 0; k < 8; k++)
        runCase("R9", W'($urandom), W'($urandom), 6'(c));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule